// File: doc/BRIEF.md
# PCI Host Bridge Control Registers and Window Translator

This block holds the software-visible control words of a PCI host bridge and turns system-side addresses that fall inside its outbound windows into 32-bit PCI memory addresses. Software programs a base word per memory window over a plain 32-bit word bus. The address decoder in front of the bridge presents a window number and the byte offset inside that window, and the block answers at once with the PCI address and an out-of-range flag. A fixed I/O window is translated alongside.

Two board variants are supported by a parameter. In the nibble variant only the four low bits of a window base word matter, and they become PCI address bits 31:28. In the aligned variant the base word is used as a high-address field, with every bit below the window size forced to zero. The variants also have different window sizes.

Top module: `pcib_ctl_xlat`

## Requirements
- R1: After reset, asserted asynchronously on rst_ni low, every register reads as zero.
- R2: Eight 32-bit registers read back exactly the last value written: window bases WBASE0/1/2 at offsets 0x00/0x04/0x08, SELF_TAG at 0x0C, CTRL_FLAGS at 0x10 and SYS_MAP0/1/2 at 0x14/0x18/0x1C. A write on a rising clock edge is visible on the combinational read port from the next cycle.
- R3: Within the 0x1000-byte register region, a word-aligned offset of 0x20 or above reads 0, and a write to it changes no register.
- R4: An access whose offset has bits 1:0 nonzero is not a valid word access: it reads 0 and a write changes no register.
- R5: With ALT_MAP=0, window n has base WBASEn[3:0] placed at bits 31:28 with bits 27:0 zero; bits 31:4 of the register have no effect.
- R6: With ALT_MAP=1, window n has base WBASEn with the bits below the window size cleared.
- R7: Window sizes are 0x0C000000, 0x10000000, 0x10000000 for windows 0..2 with ALT_MAP=0 and 0x01000000, 0x04000000, 0x08000000 with ALT_MAP=1. An offset below the size gives PCI address base+offset and flag 0; an offset at or above it gives flag 1 and address 0.
- R8: A window number of 3 or more gives flag 1 and address 0.
- R9: The I/O window has base 0 and size 0x100000 in both variants: an offset below the size is passed through with flag 0, an offset at or above it gives flag 1 and address 0.
- R10: A write to WBASEn changes translations from the next cycle; in the cycle of the write the old base is still used.
- R11: Writes to SELF_TAG, CTRL_FLAGS and SYS_MAPn have no effect on any translation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Byte offset into the register region |
| reg_we_i | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| xl_win_i | input | WIN_IW | Memory window number |
| xl_off_i | input | 32 | Byte offset inside the memory window |
| xl_addr_o | output | 32 | Translated PCI memory address |
| xl_oor_o | output | 1 | Offset or window number out of range |
| io_off_i | input | 32 | Byte offset inside the I/O window |
| io_addr_o | output | 32 | Translated PCI I/O address |
| io_oor_o | output | 1 | I/O offset out of range |

## Verification
The assertions watch, on every cycle, the relations that hold for any input: zero reads from unmapped and misaligned offsets, readback of a just-written word, the range flag against the window size, the zeroed address on a range miss, the I/O pass-through, the low offset bits appearing unchanged in the PCI address, and in the nibble variant the new base nibble showing up one cycle after a write. Only the bench scenarios show the exact base values for chosen register contents in both variants, that the non-base registers leave translations alone, that ignored writes really left every register unchanged, and the reset values after a reset in mid-run.

// File: rtl/pcib_ctl_pkg.sv
package pcib_ctl_pkg;

  localparam int WORD_W = 32;

  typedef logic [WORD_W-1:0] word_t;

  // per-variant window sizes; indices past 2 reuse the last size
  function automatic word_t win_size(input bit alt, input int idx);
    if (alt) begin
      if (idx == 0) return 32'h0100_0000;
      if (idx == 1) return 32'h0400_0000;
      return 32'h0800_0000;
    end
    if (idx == 0) return 32'h0C00_0000;
    return 32'h1000_0000;
  endfunction

endpackage

// File: rtl/pcib_reg_bank.sv
module pcib_reg_bank
  import pcib_ctl_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NUM_WIN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  word_t             wdata_i,
  output word_t             rdata_o,
  output word_t             wbase_o [NUM_WIN]
);

  // window bases, tag, flags, then one system map per window
  localparam int NREG  = 2 * NUM_WIN + 2;
  localparam int IDX_W = $clog2(NREG);

  word_t            regs_q [NREG];
  logic             hit;
  logic [IDX_W-1:0] idx;

  assign hit = (addr_i[1:0] == 2'b00) &&
               (addr_i[ADDR_W-1:2] < (ADDR_W-2)'(NREG));
  assign idx = addr_i[IDX_W+1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && hit) begin
      regs_q[idx] <= wdata_i;
    end
  end

  assign rdata_o = hit ? regs_q[idx] : '0;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_base
    assign wbase_o[g] = regs_q[g];
  end

endmodule

// File: rtl/pcib_win_xlat.sv
module pcib_win_xlat
  import pcib_ctl_pkg::*;
#(
  parameter bit    ALT_MAP  = 1'b0,
  parameter word_t WIN_SIZE = 32'h1000_0000
) (
  input  word_t base_i,
  input  word_t off_i,
  output word_t addr_o,
  output logic  oor_o
);

  word_t base;

  if (ALT_MAP) begin : g_aligned
    localparam word_t MASK = ~(WIN_SIZE - 32'd1);
    assign base = base_i & MASK;
  end else begin : g_nibble
    logic unused_hi;
    assign unused_hi = ^base_i[WORD_W-1:4];
    assign base = {base_i[3:0], 28'h0};
  end

  assign oor_o  = (off_i >= WIN_SIZE);
  assign addr_o = oor_o ? '0 : base + off_i;

endmodule

// File: rtl/pcib_io_xlat.sv
module pcib_io_xlat
  import pcib_ctl_pkg::*;
#(
  parameter word_t IO_BASE = 32'h0,
  parameter word_t IO_SIZE = 32'h0010_0000
) (
  input  word_t off_i,
  output word_t addr_o,
  output logic  oor_o
);

  assign oor_o  = (off_i >= IO_SIZE);
  assign addr_o = oor_o ? '0 : IO_BASE + off_i;

endmodule

// File: rtl/pcib_ctl_xlat.sv
module pcib_ctl_xlat
  import pcib_ctl_pkg::*;
#(
  parameter bit    ALT_MAP = 1'b0,
  parameter int    ADDR_W  = 12,
  parameter int    NUM_WIN = 3,
  parameter word_t IO_BASE = 32'h0,
  parameter word_t IO_SIZE = 32'h0010_0000,
  localparam int   WIN_IW  = $clog2(NUM_WIN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [WIN_IW-1:0] xl_win_i,
  input  logic [31:0]       xl_off_i,
  output logic [31:0]       xl_addr_o,
  output logic              xl_oor_o,
  input  logic [31:0]       io_off_i,
  output logic [31:0]       io_addr_o,
  output logic              io_oor_o
);

  word_t wbase  [NUM_WIN];
  word_t w_addr [NUM_WIN];
  logic  w_oor  [NUM_WIN];

  pcib_reg_bank #(
    .ADDR_W (ADDR_W),
    .NUM_WIN(NUM_WIN)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (reg_addr_i),
    .we_i   (reg_we_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .wbase_o(wbase)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    pcib_win_xlat #(
      .ALT_MAP (ALT_MAP),
      .WIN_SIZE(win_size(ALT_MAP, g))
    ) u_win (
      .base_i(wbase[g]),
      .off_i (xl_off_i),
      .addr_o(w_addr[g]),
      .oor_o (w_oor[g])
    );
  end

  // unknown window numbers fall through as out of range
  always_comb begin
    xl_addr_o = '0;
    xl_oor_o  = 1'b1;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (xl_win_i == WIN_IW'(i)) begin
        xl_addr_o = w_addr[i];
        xl_oor_o  = w_oor[i];
      end
    end
  end

  pcib_io_xlat #(
    .IO_BASE(IO_BASE),
    .IO_SIZE(IO_SIZE)
  ) u_io (
    .off_i (io_off_i),
    .addr_o(io_addr_o),
    .oor_o (io_oor_o)
  );

endmodule

// File: rtl/pcib_ctl_chk.sv
module pcib_ctl_chk
  import pcib_ctl_pkg::*;
#(
  parameter bit    ALT_MAP = 1'b0,
  parameter int    ADDR_W  = 12,
  parameter int    NUM_WIN = 3,
  parameter word_t IO_BASE = 32'h0,
  parameter word_t IO_SIZE = 32'h0010_0000,
  localparam int   WIN_IW  = $clog2(NUM_WIN + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_we_i,
  input logic [31:0]       reg_wdata_i,
  input logic [31:0]       reg_rdata_o,
  input logic [WIN_IW-1:0] xl_win_i,
  input logic [31:0]       xl_off_i,
  input logic [31:0]       xl_addr_o,
  input logic              xl_oor_o,
  input logic [31:0]       io_off_i,
  input logic [31:0]       io_addr_o,
  input logic              io_oor_o
);

  localparam int SPAN = 4 * (2 * NUM_WIN + 2);

  logic  aligned, mapped, win_ok;
  word_t size_sel;

  assign aligned  = (reg_addr_i[1:0] == 2'b00);
  assign mapped   = aligned && (reg_addr_i < ADDR_W'(SPAN));
  assign win_ok   = (xl_win_i < WIN_IW'(NUM_WIN));
  assign size_sel = win_size(ALT_MAP, int'(xl_win_i));

  // R2
  a_r2_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && mapped) ##1 $stable(reg_addr_i) |-> reg_rdata_o == $past(reg_wdata_i));

  a_r3_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aligned && !mapped) |-> reg_rdata_o == '0);

  a_r4_misaligned_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aligned |-> reg_rdata_o == '0);

  a_r7_over_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_ok && xl_off_i >= size_sel) |-> xl_oor_o);

  a_r7_in_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_ok && xl_off_i < size_sel) |-> !xl_oor_o);

  a_r7_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_oor_o |-> xl_addr_o == '0);

  a_r8_bad_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_ok |-> xl_oor_o);

  a_r9_io_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_off_i < IO_SIZE) |-> (!io_oor_o && io_addr_o == IO_BASE + io_off_i));

  a_r9_io_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_off_i >= IO_SIZE) |-> (io_oor_o && io_addr_o == '0));

  if (ALT_MAP) begin : g_alt
    a_r6_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (win_ok && !xl_oor_o) |-> (xl_addr_o & (size_sel - 32'd1)) == xl_off_i);
  end else begin : g_pri
    a_r5_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (win_ok && !xl_oor_o) |-> xl_addr_o[27:0] == xl_off_i[27:0]);

    a_r10_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && win_ok && reg_addr_i == ADDR_W'({xl_win_i, 2'b00}))
        ##1 ($stable(xl_win_i) && $stable(xl_off_i) && !xl_oor_o)
        |-> xl_addr_o[31:28] == $past(reg_wdata_i[3:0]));
  end

endmodule

bind pcib_ctl_xlat pcib_ctl_chk #(
  .ALT_MAP(ALT_MAP),
  .ADDR_W (ADDR_W),
  .NUM_WIN(NUM_WIN),
  .IO_BASE(IO_BASE),
  .IO_SIZE(IO_SIZE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_addr_i (reg_addr_i),
  .reg_we_i   (reg_we_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .xl_win_i   (xl_win_i),
  .xl_off_i   (xl_off_i),
  .xl_addr_o  (xl_addr_o),
  .xl_oor_o   (xl_oor_o),
  .io_off_i   (io_off_i),
  .io_addr_o  (io_addr_o),
  .io_oor_o   (io_oor_o)
);

// File: tb/sim_pcib_ctl_xlat.sv
`timescale 1ns/1ps
module sim_pcib_ctl_xlat;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  xl_win = '0;
  logic [31:0] xl_off = '0;
  logic [31:0] io_off = '0;

  logic [31:0] rd0, rd1, xa0, xa1, ia0, ia1;
  logic        xo0, xo1, io0, io1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pcib_ctl_xlat #(.ALT_MAP(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_we_i(reg_we),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rd0), .xl_win_i(xl_win), .xl_off_i(xl_off),
    .xl_addr_o(xa0), .xl_oor_o(xo0), .io_off_i(io_off), .io_addr_o(ia0), .io_oor_o(io0)
  );

  pcib_ctl_xlat #(.ALT_MAP(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_we_i(reg_we),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rd1), .xl_win_i(xl_win), .xl_off_i(xl_off),
    .xl_addr_o(xa1), .xl_oor_o(xo1), .io_off_i(io_off), .io_addr_o(ia1), .io_oor_o(io1)
  );

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] data;   // write data, or expected read data
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 12'h000, 32'hA5A5_0003, 4'd2}, '{1'b1, 12'h004, 32'h1234_5678, 4'd2},
    '{1'b1, 12'h008, 32'hFFFF_FFFF, 4'd2}, '{1'b1, 12'h00C, 32'hDEAD_BEEF, 4'd2},
    '{1'b1, 12'h010, 32'h0000_00F0, 4'd2}, '{1'b1, 12'h014, 32'h1111_1111, 4'd2},
    '{1'b1, 12'h018, 32'h2222_2222, 4'd2}, '{1'b1, 12'h01C, 32'h3333_3333, 4'd2},
    '{1'b0, 12'h01C, 32'h3333_3333, 4'd2}, '{1'b0, 12'h000, 32'hA5A5_0003, 4'd2},
    '{1'b0, 12'h008, 32'hFFFF_FFFF, 4'd2}, '{1'b0, 12'h010, 32'h0000_00F0, 4'd2},
    '{1'b0, 12'h004, 32'h1234_5678, 4'd2}, '{1'b0, 12'h018, 32'h2222_2222, 4'd2},
    '{1'b0, 12'h00C, 32'hDEAD_BEEF, 4'd2}, '{1'b0, 12'h014, 32'h1111_1111, 4'd2},
    '{1'b1, 12'h020, 32'h0000_CAFE, 4'd3}, '{1'b0, 12'h020, 32'h0000_0000, 4'd3},
    '{1'b1, 12'hFFC, 32'h0BAD_F00D, 4'd3}, '{1'b0, 12'hFFC, 32'h0000_0000, 4'd3},
    '{1'b0, 12'h01C, 32'h3333_3333, 4'd3},
    '{1'b1, 12'h002, 32'h5555_5555, 4'd4}, '{1'b0, 12'h002, 32'h0000_0000, 4'd4},
    '{1'b0, 12'h000, 32'hA5A5_0003, 4'd4}, '{1'b1, 12'h00D, 32'h7777_7777, 4'd4},
    '{1'b0, 12'h00C, 32'hDEAD_BEEF, 4'd4}, '{1'b0, 12'h00D, 32'h0000_0000, 4'd4}
  };

  function automatic string tag_of(input logic [3:0] r);
    case (r)
      4'd2:    return "R2";
      4'd3:    return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk({tag, " u0 read"}, rd0, exp);
    chk({tag, " u1 read"}, rd1, exp);
  endtask

  task automatic xl_chk(input string tag, input logic [1:0] w, input logic [31:0] o,
                        input logic [31:0] e0, input logic e0o,
                        input logic [31:0] e1, input logic e1o);
    xl_win = w; xl_off = o;
    #1;
    chk({tag, " u0 addr"}, xa0, e0);
    chk({tag, " u0 flag"}, {31'b0, xo0}, {31'b0, e0o});
    chk({tag, " u1 addr"}, xa1, e1);
    chk({tag, " u1 flag"}, {31'b0, xo1}, {31'b0, e1o});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values, and a zero base after reset
    for (int i = 0; i < 8; i++) rd_chk("R1", 12'(4 * i), 32'h0);
    xl_chk("R1 zero base", 2'd1, 32'h10, 32'h10, 1'b0, 32'h10, 1'b0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].we) wr(VEC[i].addr, VEC[i].data);
      else rd_chk(tag_of(VEC[i].req), VEC[i].addr, VEC[i].data);
    end

    // bases now 0xA5A50003, 0x12345678, 0xFFFFFFFF
    @(negedge clk);
    xl_chk("R5 R6 win0", 2'd0, 32'h10, 32'h3000_0010, 1'b0, 32'hA500_0010, 1'b0);
    xl_chk("R7 win0 top", 2'd0, 32'h00FF_FFFF, 32'h30FF_FFFF, 1'b0, 32'hA5FF_FFFF, 1'b0);
    xl_chk("R7 win0 edge", 2'd0, 32'h0100_0000, 32'h3100_0000, 1'b0, 32'h0, 1'b1);
    xl_chk("R7 win0 last", 2'd0, 32'h0BFF_FFFF, 32'h3BFF_FFFF, 1'b0, 32'h0, 1'b1);
    xl_chk("R7 win0 over", 2'd0, 32'h0C00_0000, 32'h0, 1'b1, 32'h0, 1'b1);
    xl_chk("R6 win1", 2'd1, 32'h03FF_FFFF, 32'h83FF_FFFF, 1'b0, 32'h13FF_FFFF, 1'b0);
    xl_chk("R7 win1 edge", 2'd1, 32'h0400_0000, 32'h8400_0000, 1'b0, 32'h0, 1'b1);
    xl_chk("R7 win1 last", 2'd1, 32'h0FFF_FFFF, 32'h8FFF_FFFF, 1'b0, 32'h0, 1'b1);
    xl_chk("R7 win1 over", 2'd1, 32'h1000_0000, 32'h0, 1'b1, 32'h0, 1'b1);
    xl_chk("R6 win2", 2'd2, 32'h07FF_FFFF, 32'hF7FF_FFFF, 1'b0, 32'hFFFF_FFFF, 1'b0);
    xl_chk("R7 win2 edge", 2'd2, 32'h0800_0000, 32'hF800_0000, 1'b0, 32'h0, 1'b1);
    xl_chk("R8 win3", 2'd3, 32'h0, 32'h0, 1'b1, 32'h0, 1'b1);

    // R9: I/O window
    io_off = 32'h000F_FFFF; #1;
    chk("R9 io pass u0", ia0, 32'h000F_FFFF);
    chk("R9 io pass u1", ia1, 32'h000F_FFFF);
    chk("R9 io flag", {30'b0, io0, io1}, 32'h0);
    io_off = 32'h0010_0000; #1;
    chk("R9 io over u0", ia0, 32'h0);
    chk("R9 io over flag", {30'b0, io0, io1}, 32'h3);

    // R11: other registers leave translation alone
    wr(12'h00C, 32'hFFFF_FFFF);
    wr(12'h010, 32'h0F0F_0F0F);
    wr(12'h014, 32'hFFFF_0000);
    wr(12'h01C, 32'h0000_FFFF);
    @(negedge clk);
    xl_chk("R11 win0", 2'd0, 32'h20, 32'h3000_0020, 1'b0, 32'hA500_0020, 1'b0);

    // R10: new base only after the write edge
    @(negedge clk);
    xl_win = 2'd0; xl_off = 32'h4;
    reg_addr = 12'h000; reg_wdata = 32'h0600_0005; reg_we = 1'b1;
    #1;
    chk("R10 old base u0", xa0, 32'h3000_0004);
    chk("R10 old base u1", xa1, 32'hA500_0004);
    @(negedge clk);
    reg_we = 1'b0;
    #1;
    chk("R10 new base u0", xa0, 32'h5000_0004);
    chk("R10 new base u1", xa1, 32'h0600_0004);

    // R1: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_chk("R1 after reset", 12'h000, 32'h0);
    rd_chk("R1 after reset", 12'h01C, 32'h0);
    xl_chk("R1 base cleared", 2'd2, 32'h8, 32'h8, 1'b0, 32'h8, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule